// File: doc/BRIEF.md
# Event Interrupt Cause and Mask Controller

This block gathers a vector of event inputs, by default 32 of them, into a pending-cause register. It gates that register with an enable mask and drives a single combined interrupt line towards a parent interrupt controller. Software reaches both registers through a flat register port: an address, a write strobe, write data and combinational read data. The cause register sits at byte offset 0x50 and the mask register at 0x54.

The cause register is ordinary read/write storage, not write-one-to-clear. Every written bit takes the value given, so a 1 raises that interrupt and a 0 drops it. Clearing one source therefore means a read-modify-write of the whole word. A stale word written back can bring an already-cleared bit back to life. To keep new events from being lost in that window, a rising edge on an event input takes priority over a software write to the same bit in the same cycle.

The combined line comes from a two-state machine. `IRQ_QUIET` drives the line low and `IRQ_RAISED` drives it high. The transition `QUIET->RAISED` is taken when any enabled cause bit is set. `RAISED->QUIET` is taken when none is set. The machine stays in its state otherwise. Because the line is the state register itself, it follows a cause or mask change by one clock.

Top module: `evt_irq_ctrl`

## Requirements
- R1: After reset the cause register and the mask register both read as zero, and the interrupt line is low.
- R2: A rising edge (low in one cycle, high in the next) on event input i sets cause bit i. An input held high sets the bit only once, and does not set it again after software clears it.
- R3: A write to offset 0x50 loads every cause bit with the written value: a 1 sets the bit and a 0 clears it. Bit i of the data word maps to source i.
- R4: A write to offset 0x54 loads the mask register, where bit i = 1 enables source i and 0 disables it. A read of 0x54 returns the stored value.
- R5: The interrupt line is registered. It is high in the cycle after any bit of (cause AND mask) is set, and low in the cycle after none is set. This is the `IRQ_QUIET` / `IRQ_RAISED` machine described above.
- R6: A cause bit whose mask bit is 0 never drives the interrupt line high.
- R7: When an event edge and a cause write land on the same bit in the same cycle, the bit ends up set whatever value was written.
- R8: A read of any offset other than 0x50 or 0x54 returns zero. A write to such an offset changes neither register.
- R9: Writing back an earlier-read cause word re-raises a bit that was cleared in the meantime, and the line goes high again if that bit is enabled.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| evt_i | input | NUM_SRC | Event inputs, one per source |
| reg_addr | input | ADDR_W | Register byte offset |
| reg_we | input | 1 | Write strobe, one cycle per write |
| reg_wdata | input | DATA_W | Write data |
| reg_rdata | output | DATA_W | Read data for reg_addr, combinational |
| irq_o | output | 1 | Combined interrupt to the parent controller |

## Verification
The bench goes after the same-cycle collision between an event edge and a clearing write. A design that lets the write win would lose that event silently. It checks that a source held high is not re-latched after a clear; a level-sampling design would re-raise the bit forever. It writes a stale cause word back to show the cleared bit returns, which a write-one-to-clear design would fail. It holds enabled and disabled sources against the line, and samples the line one cycle after each change so that an unregistered or late output shows up. Unmapped offsets are written with all ones and both registers read back, which catches a decoder that aliases addresses.

// File: rtl/evt_irq_pkg.sv
package evt_irq_pkg;

    typedef enum logic {
        IRQ_QUIET  = 1'b0,
        IRQ_RAISED = 1'b1
    } irq_state_e;

    localparam int unsigned DEF_CAUSE_OFS = 32'h50;
    localparam int unsigned DEF_MASK_OFS  = 32'h54;

endpackage

// File: rtl/evt_irq_regs.sv
module evt_irq_regs #(
    parameter int unsigned NUM_SRC   = 32,
    parameter int unsigned ADDR_W    = 8,
    parameter int unsigned DATA_W    = 32,
    parameter int unsigned CAUSE_OFS = 32'h50,
    parameter int unsigned MASK_OFS  = 32'h54
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [ADDR_W-1:0]  reg_addr,
    input  logic               reg_we,
    input  logic [DATA_W-1:0]  reg_wdata,
    input  logic [NUM_SRC-1:0] cause_q,
    output logic               cause_we,
    output logic [NUM_SRC-1:0] cause_wval,
    output logic [NUM_SRC-1:0] mask_q,
    output logic [DATA_W-1:0]  reg_rdata
);
    localparam logic [ADDR_W-1:0] A_CAUSE = ADDR_W'(CAUSE_OFS);
    localparam logic [ADDR_W-1:0] A_MASK  = ADDR_W'(MASK_OFS);

    logic hit_cause;
    logic hit_mask;

    always_comb begin
        hit_cause = (reg_addr == A_CAUSE);
        hit_mask  = (reg_addr == A_MASK);
    end

    always_comb begin
        cause_we   = reg_we && hit_cause;
        cause_wval = reg_wdata[NUM_SRC-1:0];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mask_q <= '0;
        end else if (reg_we && hit_mask) begin
            mask_q <= reg_wdata[NUM_SRC-1:0];
        end
    end

    always_comb begin
        reg_rdata = '0;
        if (hit_cause) begin
            reg_rdata = DATA_W'(cause_q);
        end else if (hit_mask) begin
            reg_rdata = DATA_W'(mask_q);
        end
    end

endmodule

// File: rtl/evt_irq_cause.sv
module evt_irq_cause #(
    parameter int unsigned NUM_SRC = 32
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] evt_i,
    input  logic               cause_we,
    input  logic [NUM_SRC-1:0] cause_wval,
    output logic [NUM_SRC-1:0] cause_q
);
    logic [NUM_SRC-1:0] evt_prev;
    logic [NUM_SRC-1:0] evt_rise;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            evt_prev <= '0;
        end else begin
            evt_prev <= evt_i;
        end
    end

    always_comb begin
        evt_rise = evt_i & ~evt_prev;
    end

    // One storage bit per source; an event edge outranks a software write.
    for (genvar g = 0; g < NUM_SRC; g++) begin : g_bit
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                cause_q[g] <= 1'b0;
            end else if (evt_rise[g]) begin
                cause_q[g] <= 1'b1;
            end else if (cause_we) begin
                cause_q[g] <= cause_wval[g];
            end
        end
    end

endmodule

// File: rtl/evt_irq_fsm.sv
module evt_irq_fsm
    import evt_irq_pkg::*;
#(
    parameter int unsigned NUM_SRC = 32
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] cause_q,
    input  logic [NUM_SRC-1:0] mask_q,
    output logic               irq_o
);
    irq_state_e state_q;
    irq_state_e state_d;
    logic       any_live;

    always_comb begin
        any_live = |(cause_q & mask_q);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= IRQ_QUIET;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            IRQ_QUIET:  if (any_live)  state_d = IRQ_RAISED;
            IRQ_RAISED: if (!any_live) state_d = IRQ_QUIET;
            default:    state_d = IRQ_QUIET;
        endcase
    end

    always_comb begin
        irq_o = (state_q == IRQ_RAISED);
    end

endmodule

// File: rtl/evt_irq_ctrl.sv
module evt_irq_ctrl #(
    parameter int unsigned NUM_SRC   = 32,
    parameter int unsigned ADDR_W    = 8,
    parameter int unsigned DATA_W    = 32,
    parameter int unsigned CAUSE_OFS = evt_irq_pkg::DEF_CAUSE_OFS,
    parameter int unsigned MASK_OFS  = evt_irq_pkg::DEF_MASK_OFS
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] evt_i,
    input  logic [ADDR_W-1:0]  reg_addr,
    input  logic               reg_we,
    input  logic [DATA_W-1:0]  reg_wdata,
    output logic [DATA_W-1:0]  reg_rdata,
    output logic               irq_o
);
    logic [NUM_SRC-1:0] cause_q;
    logic [NUM_SRC-1:0] mask_q;
    logic               cause_we;
    logic [NUM_SRC-1:0] cause_wval;

    evt_irq_regs #(
        .NUM_SRC(NUM_SRC), .ADDR_W(ADDR_W), .DATA_W(DATA_W),
        .CAUSE_OFS(CAUSE_OFS), .MASK_OFS(MASK_OFS)
    ) u_regs (
        .clk(clk), .rst_n(rst_n),
        .reg_addr(reg_addr), .reg_we(reg_we), .reg_wdata(reg_wdata),
        .cause_q(cause_q), .cause_we(cause_we), .cause_wval(cause_wval),
        .mask_q(mask_q), .reg_rdata(reg_rdata)
    );

    evt_irq_cause #(.NUM_SRC(NUM_SRC)) u_cause (
        .clk(clk), .rst_n(rst_n), .evt_i(evt_i),
        .cause_we(cause_we), .cause_wval(cause_wval), .cause_q(cause_q)
    );

    evt_irq_fsm #(.NUM_SRC(NUM_SRC)) u_fsm (
        .clk(clk), .rst_n(rst_n),
        .cause_q(cause_q), .mask_q(mask_q), .irq_o(irq_o)
    );

endmodule

// File: rtl/evt_irq_ctrl_chk.sv
module evt_irq_ctrl_chk #(
    parameter int unsigned NUM_SRC   = 32,
    parameter int unsigned ADDR_W    = 8,
    parameter int unsigned DATA_W    = 32,
    parameter int unsigned CAUSE_OFS = 32'h50,
    parameter int unsigned MASK_OFS  = 32'h54
) (
    input logic               clk,
    input logic               rst_n,
    input logic [NUM_SRC-1:0] evt_i,
    input logic [ADDR_W-1:0]  reg_addr,
    input logic               reg_we,
    input logic [DATA_W-1:0]  reg_wdata,
    input logic               irq_o,
    input logic [NUM_SRC-1:0] cause_q,
    input logic [NUM_SRC-1:0] mask_q
);
    logic [NUM_SRC-1:0] seen_evt;
    logic [NUM_SRC-1:0] rise_seen;
    logic               wr_cause;
    logic               wr_mask;

    always_ff @(posedge clk) begin
        if (!rst_n) seen_evt <= '0;
        else        seen_evt <= evt_i;
    end

    always_comb begin
        rise_seen = evt_i & ~seen_evt;
        wr_cause  = reg_we && (reg_addr == ADDR_W'(CAUSE_OFS));
        wr_mask   = reg_we && (reg_addr == ADDR_W'(MASK_OFS));
    end

    p_edge_sets_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (rise_seen != '0) |=> ((cause_q & $past(rise_seen)) == $past(rise_seen)));

    // R3 and R7: a written word lands, with edges of that cycle forced to 1
    p_cause_write_r3: assert property (@(posedge clk) disable iff (!rst_n)
        wr_cause |=> (cause_q == ($past(reg_wdata[NUM_SRC-1:0]) | $past(rise_seen))));

    p_mask_write_r4: assert property (@(posedge clk) disable iff (!rst_n)
        wr_mask |=> (mask_q == $past(reg_wdata[NUM_SRC-1:0])));

    p_mask_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_mask |=> $stable(mask_q));

    p_irq_rise_r5: assert property (@(posedge clk) disable iff (!rst_n)
        ((cause_q & mask_q) != '0) |=> irq_o);

    p_irq_fall_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ((cause_q & mask_q) == '0) |=> !irq_o);

endmodule

bind evt_irq_ctrl evt_irq_ctrl_chk #(
    .NUM_SRC(NUM_SRC), .ADDR_W(ADDR_W), .DATA_W(DATA_W),
    .CAUSE_OFS(CAUSE_OFS), .MASK_OFS(MASK_OFS)
) u_chk (
    .clk(clk), .rst_n(rst_n), .evt_i(evt_i),
    .reg_addr(reg_addr), .reg_we(reg_we), .reg_wdata(reg_wdata),
    .irq_o(irq_o), .cause_q(cause_q), .mask_q(mask_q)
);

// File: tb/tb_evt_irq_ctrl.sv
module tb_evt_irq_ctrl;
    localparam int unsigned NS = 32;
    localparam logic [7:0] A_CAUSE = 8'h50;
    localparam logic [7:0] A_MASK  = 8'h54;
    localparam logic [7:0] A_HOLE  = 8'h58;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [NS-1:0] evt = '0;
    logic [7:0]    addr = '0;
    logic          we = 1'b0;
    logic [31:0]   wdata = '0;
    logic [31:0]   rdata;
    logic          irq;
    int            total = 0;
    int            bad = 0;
    logic [31:0]   stale;

    always #2 clk = ~clk;

    evt_irq_ctrl dut (
        .clk(clk), .rst_n(rst_n), .evt_i(evt),
        .reg_addr(addr), .reg_we(we), .reg_wdata(wdata),
        .reg_rdata(rdata), .irq_o(irq)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: got %h want %h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        addr = a; wdata = d; we = 1'b1;
        @(negedge clk);
        we = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        @(negedge clk);
        addr = a;
        #1 d = rdata;
    endtask

    task automatic t_reset();
        logic [31:0] v;
        rd(A_CAUSE, v); check("R1 cause", v, 0);
        rd(A_MASK, v);  check("R1 mask", v, 0);
        check("R1 irq", {31'b0, irq}, 0);
    endtask

    task automatic t_edge_masked();
        logic [31:0] v;
        @(negedge clk); evt[3] = 1'b1;
        rd(A_CAUSE, v); check("R2 edge sets bit3", v, 32'h8);
        repeat (3) @(negedge clk);
        check("R6 masked source quiet", {31'b0, irq}, 0);
        stale = v;
    endtask

    task automatic t_enable();
        logic [31:0] v;
        wr(A_MASK, 32'h8);
        check("R5 irq one cycle late", {31'b0, irq}, 0);
        @(negedge clk);
        check("R5 irq raised", {31'b0, irq}, 1);
        rd(A_MASK, v); check("R4 mask readback", v, 32'h8);
    endtask

    task automatic t_clear_held();
        logic [31:0] v;
        wr(A_CAUSE, 32'h0);
        check("R5 irq still high", {31'b0, irq}, 1);
        @(negedge clk);
        check("R5 irq dropped", {31'b0, irq}, 0);
        repeat (3) @(negedge clk);
        rd(A_CAUSE, v); check("R2 held level not relatched / R3 clear", v, 0);
    endtask

    task automatic t_stale();
        logic [31:0] v;
        wr(A_CAUSE, stale);
        rd(A_CAUSE, v); check("R9 stale writeback re-raises", v, 32'h8);
        check("R9 irq back", {31'b0, irq}, 1);
    endtask

    task automatic t_write_set();
        logic [31:0] v;
        wr(A_CAUSE, 32'h0000_0001);
        rd(A_CAUSE, v); check("R3 write one sets, zero clears", v, 32'h1);
        @(negedge clk);
        check("R6 bit0 disabled keeps irq low", {31'b0, irq}, 0);
    endtask

    task automatic t_race();
        logic [31:0] v;
        @(negedge clk);
        addr = A_CAUSE; wdata = 32'h0; we = 1'b1; evt[5] = 1'b1;
        @(negedge clk);
        we = 1'b0;
        rd(A_CAUSE, v); check("R7 edge beats clearing write", v, 32'h20);
    endtask

    task automatic t_hole();
        logic [31:0] v;
        wr(A_HOLE, 32'hFFFF_FFFF);
        rd(A_HOLE, v);  check("R8 unmapped reads zero", v, 0);
        rd(A_MASK, v);  check("R8 mask untouched", v, 32'h8);
        rd(A_CAUSE, v); check("R8 cause untouched", v, 32'h20);
    endtask

    initial begin
        #(4 * 100000);
        total++; bad++;
        $display("FAIL watchdog: got timeout want completion");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_edge_masked();
        t_enable();
        t_clear_held();
        t_stale();
        t_write_set();
        t_race();
        t_hole();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule